// File: doc/BRIEF.md
# Noise-aware power-gating sequencer

This block sequences power-gating events for a mesh of sixteen processing units. Switching one unit's power draws a large transient current from the shared supply grid. That disturbs the units around it. Before any unit changes power state, the sequencer therefore stops the clocks of the neighbours that could be hurt. It then flips the unit's power enable and waits for the supply to settle. Finally it restarts the neighbours' clocks and acknowledges the request.

A unit being switched is the attacker. A neighbour counts as a victim only when all of these hold:
- it is powered;
- it is running a task;
- it lies inside the attacker's impact set.

Impact sets come from a 16x16 bit map that is captured while reset is held. A mode input replaces the impact sets with conservative stop-go protection, which gates every active unit except the attacker.

Requests are level signals, one pair per unit. When several are pending, the lowest unit index is served first. Only one attack sequence runs at a time, so protection windows never overlap. A requester drops its request in the cycle it sees its acknowledge.

Top module: `pgs_sequencer`

## Requirements
- R1: Victims are exactly the units that are powered, have their task flag set and lie in the attacker's impact set. Bit `a*16+v` of the impact map set means unit v is in the set of attacker a. The attacker itself is never clock-gated.
- R2: A powered unit whose task flag is clear, and an unpowered unit, is never clock-gated, whatever the mode.
- R3: With `stop_go` high, every powered unit with its task flag set is clock-gated, apart from the attacker, regardless of the impact map.
- R4: Take the request as sampled at edge 0. The victim clock gates are visible one cycle later (cycle 1), together with `busy`. The attacker's power enable flips 100 cycles after that (cycle 101).
- R5: The victims stay gated until the power flip has settled for 200 cycles. They are released at cycle 301.
- R6: The acknowledge for the attacker is a one-cycle pulse at cycle 401, 100 cycles after release. `busy` falls in the same cycle.
- R7: Only one sequence runs at a time. Among pending requests the lowest unit index wins. A waiting unit's power enable does not change until its own sequence runs.
- R8: A request for the power state a unit already has is acknowledged at cycle 1. It causes no gating, no `busy` and no power change.
- R9: After reset, power enables, clock gates, acknowledges and `busy` are all low. The impact map is taken only while reset is low, so later changes on that input have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the impact map is captured while low |
| impact_map | input | 256 | Impact sets; bit a*16+v set puts unit v in attacker a's set |
| stop_go | input | 1 | 1 = gate all active units; 0 = use the impact sets |
| pwr_on_req | input | 16 | Per-unit request to power on (level; wins over power off) |
| pwr_off_req | input | 16 | Per-unit request to power off (level) |
| task_active | input | 16 | Per-unit flag: the unit is running a task |
| pwr_en | output | 16 | Per-unit power enable |
| clk_gate | output | 16 | Per-unit clock-gate enable (1 = clock stopped) |
| req_ack | output | 16 | Per-unit one-cycle acknowledge when a request completes |
| busy | output | 1 | An attack sequence is in progress |

## Verification
The sequences use the following patterns:
- **Nothing powered.** The gate mask stays empty.
- **Corner attacker with an active neighbour inside its range.** The neighbour is gated.
- **Corner attacker with active units only outside its range.** Nobody is gated. Because the impact-map input is driven to all ones after reset, this case also shows that the captured map is used and not the live input.
- **Interior attacker with an active flag on an unpowered unit.** This separates "active" from "powered and active".
- **Stop-go attacker with powered idle units present.** This separates the stop-go rule from the impact-set rule.
- **Power-off attack.** This checks the flip in the other direction.

For each sequence the bench records the cycle at which gating appears, the power flip, the release and the acknowledge. Redundant requests check the immediate acknowledge. Two simultaneous requests check the priority order and the serialisation.

// File: rtl/pgs_pkg.sv
// Shared types for the power-gating sequencer.
// Assumes: one attack sequence is active at a time.
package pgs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_POWER = 2'd2,
        ST_WAKE  = 2'd3
    } pgs_state_e;
endpackage

// File: rtl/pgs_arbiter.sv
// Fixed-priority arbiter: returns the lowest index with a pending request.
// Assumes: purely combinational, the caller samples the result when idle.
module pgs_arbiter #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set index is the last one written.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pgs_victim_sel.sv
// Victim selector: the powered, active units that an attacker would disturb.
// Assumes: imp holds one N-bit row per attacker; the attacker is never its own victim.
module pgs_victim_sel #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N*N-1:0] imp,
    input  logic [IW-1:0]  att,
    input  logic           stop_go,
    input  logic [N-1:0]   active,
    input  logic [N-1:0]   powered,
    output logic [N-1:0]   victims
);
    logic [N-1:0] row;
    logic [N-1:0] self_bit;

    // Pull out the attacker's impact row.
    always_comb begin
        for (int v = 0; v < N; v++) begin
            row[v] = imp[int'(att) * N + v];
        end
    end

    // One-hot of the attacker, used to exclude it from the victims.
    assign self_bit = N'(1) << att;

    // Stop-go widens the candidate set to everyone; only live units qualify.
    always_comb begin
        victims = (stop_go ? {N{1'b1}} : row) & active & powered & ~self_bit;
    end
endmodule

// File: rtl/pgs_phase_timer.sv
// Phase timer: counts cycles within one sequence phase and flags the last one.
// Assumes: last is held constant while run is high within one phase.
module pgs_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] last,
    output logic          expire
);
    logic [CW-1:0] cnt;

    assign expire = run && (cnt == last);

    // Count up while a phase runs; restart at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pgs_sequencer.sv
// Noise-aware power-gating sequencer (top).
// Serves one power on/off request at a time, lowest unit first. It gates the
// victims, flips the power, waits for settling, then releases and acknowledges.
// Assumes: requests are held until acknowledged and dropped in the ack cycle;
// the impact map is stable while reset is low.
module pgs_sequencer #(
    parameter int NUM_UNITS     = 16,
    parameter int GATE_CYCLES   = 100,
    parameter int SETTLE_CYCLES = 200,
    parameter int WAKE_CYCLES   = 100,
    localparam int IW   = $clog2(NUM_UNITS),
    localparam int MAXC = (GATE_CYCLES > SETTLE_CYCLES)
                        ? ((GATE_CYCLES > WAKE_CYCLES) ? GATE_CYCLES : WAKE_CYCLES)
                        : ((SETTLE_CYCLES > WAKE_CYCLES) ? SETTLE_CYCLES : WAKE_CYCLES),
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_UNITS*NUM_UNITS-1:0] impact_map,
    input  logic                           stop_go,
    input  logic [NUM_UNITS-1:0]           pwr_on_req,
    input  logic [NUM_UNITS-1:0]           pwr_off_req,
    input  logic [NUM_UNITS-1:0]           task_active,
    output logic [NUM_UNITS-1:0]           pwr_en,
    output logic [NUM_UNITS-1:0]           clk_gate,
    output logic [NUM_UNITS-1:0]           req_ack,
    output logic                           busy
);
    import pgs_pkg::*;

    pgs_state_e                     state;
    logic [NUM_UNITS*NUM_UNITS-1:0] imp_q;
    logic [IW-1:0]                  att_q;
    logic [NUM_UNITS-1:0]           pend_on;
    logic [NUM_UNITS-1:0]           pend_off;
    logic                           arb_valid;
    logic [IW-1:0]                  arb_idx;
    logic                           trivial;
    logic [NUM_UNITS-1:0]           victims;
    logic [CW-1:0]                  last;
    logic                           expire;

    // Capture the impact sets only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imp_q <= impact_map;
        end
    end

    // Pending requests; a unit being acknowledged is masked for that cycle.
    assign pend_on  = pwr_on_req & ~req_ack;
    assign pend_off = pwr_off_req & ~pwr_on_req & ~req_ack;

    pgs_arbiter #(.N(NUM_UNITS)) u_arb (
        .req   (pend_on | pend_off),
        .valid (arb_valid),
        .idx   (arb_idx)
    );

    // A request for the state the unit already has needs no sequence.
    assign trivial = pend_on[arb_idx] ? pwr_en[arb_idx] : ~pwr_en[arb_idx];

    pgs_victim_sel #(.N(NUM_UNITS)) u_vsel (
        .imp     (imp_q),
        .att     (arb_idx),
        .stop_go (stop_go),
        .active  (task_active),
        .powered (pwr_en),
        .victims (victims)
    );

    // Length of the current phase, minus one.
    always_comb begin
        case (state)
            ST_GATE:  last = CW'(GATE_CYCLES - 1);
            ST_POWER: last = CW'(SETTLE_CYCLES - 1);
            ST_WAKE:  last = CW'(WAKE_CYCLES - 1);
            default:  last = '0;
        endcase
    end

    pgs_phase_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state != ST_IDLE),
        .last   (last),
        .expire (expire)
    );

    // Sequence control: grant, gate, power flip, settle, release, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            att_q    <= '0;
            pwr_en   <= '0;
            clk_gate <= '0;
            req_ack  <= '0;
        end else begin
            req_ack <= '0;
            case (state)
                ST_IDLE: begin
                    if (arb_valid) begin
                        if (trivial) begin
                            req_ack[arb_idx] <= 1'b1;
                        end else begin
                            att_q    <= arb_idx;
                            clk_gate <= victims;
                            state    <= ST_GATE;
                        end
                    end
                end
                ST_GATE: begin
                    if (expire) begin
                        pwr_en[att_q] <= ~pwr_en[att_q];
                        state         <= ST_POWER;
                    end
                end
                ST_POWER: begin
                    if (expire) begin
                        clk_gate <= '0;
                        state    <= ST_WAKE;
                    end
                end
                default: begin
                    if (expire) begin
                        req_ack[att_q] <= 1'b1;
                        state          <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pgs_sequencer_chk.sv
// Checker for the power-gating sequencer, attached by bind.
// Assumes: requests are dropped in the cycle their acknowledge is seen.
module pgs_sequencer_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] task_active,
    input logic [N-1:0] pwr_en,
    input logic [N-1:0] clk_gate,
    input logic [N-1:0] req_ack,
    input logic         busy
);
    AST_GATE_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ((clk_gate & ~($past(task_active) & $past(pwr_en))) == '0)); // R2

    AST_ONE_PWR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwr_en ^ $past(pwr_en)) <= 1); // R7

    AST_PWR_FLIP_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en != $past(pwr_en)) |-> (busy && $past(busy))); // R8

    AST_GATE_HELD_AT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en != $past(pwr_en)) |-> $stable(clk_gate)); // R5

    AST_NO_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (clk_gate == '0)); // R6

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ack)); // R7

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ack & $past(req_ack)) == '0)); // R6
endmodule

bind pgs_sequencer pgs_sequencer_chk #(.N(NUM_UNITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .task_active (task_active),
    .pwr_en      (pwr_en),
    .clk_gate    (clk_gate),
    .req_ack     (req_ack),
    .busy        (busy)
);

// File: tb/sim_pgs_sequencer.sv
module sim_pgs_sequencer;
    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*N-1:0] impact_map = '0;
    logic           stop_go = 1'b0;
    logic [N-1:0]   pwr_on_req = '0;
    logic [N-1:0]   pwr_off_req = '0;
    logic [N-1:0]   task_active = '0;
    logic [N-1:0]   pwr_en;
    logic [N-1:0]   clk_gate;
    logic [N-1:0]   req_ack;
    logic           busy;

    int n_chk = 0;
    int n_fail = 0;
    logic [N-1:0] model_pwr = '0;

    always #2 clk = ~clk;

    pgs_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .impact_map(impact_map), .stop_go(stop_go),
        .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req), .task_active(task_active),
        .pwr_en(pwr_en), .clk_gate(clk_gate), .req_ack(req_ack), .busy(busy)
    );

    // Mesh impact rule: interior units reach everyone, border units reach Manhattan distance 2.
    function automatic bit in_range(int a, int v);
        int ra = a / 4, ca = a % 4, rv = v / 4, cv = v % 4;
        int dr = (ra > rv) ? ra - rv : rv - ra;
        int dc = (ca > cv) ? ca - cv : cv - ca;
        bit border = (ra == 0) || (ra == 3) || (ca == 0) || (ca == 3);
        if (a == v) return 1'b0;
        if (!border) return 1'b1;
        return (dr + dc) <= 2;
    endfunction

    function automatic logic [N-1:0] exp_victims(int a, bit sg, logic [N-1:0] act, logic [N-1:0] pw);
        logic [N-1:0] m = '0;
        for (int v = 0; v < N; v++) begin
            if (v != a && act[v] && pw[v] && (sg || in_range(a, v))) m[v] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(bit ok, string req, string what, int actual, int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Runs one request; times are cycles after the grant edge (k = 1 is the first sample).
    task automatic run_seq(int u, bit on, bit sg, logic [N-1:0] act, bit triv_exp);
        logic [N-1:0] exp_mask, g1, prev_pw, prev_g;
        bit triv, b1;
        int t_pwr = 0, t_rel = 0, t_ack = 0;
        triv = (on == model_pwr[u]);
        check(triv == triv_exp, "R8", "vector triviality", int'(triv), int'(triv_exp));
        exp_mask = triv ? '0 : exp_victims(u, sg, act, model_pwr);
        stop_go = sg;
        task_active = act;
        if (on) pwr_on_req[u] = 1'b1; else pwr_off_req[u] = 1'b1;
        prev_pw = pwr_en;
        prev_g = clk_gate;
        g1 = '0;
        b1 = 1'b0;
        for (int k = 1; k <= 500; k++) begin
            tick();
            if (k == 1) begin g1 = clk_gate; b1 = busy; end
            if (pwr_en != prev_pw && t_pwr == 0) t_pwr = k;
            if (prev_g != '0 && clk_gate == '0 && t_rel == 0) t_rel = k;
            prev_pw = pwr_en;
            prev_g = clk_gate;
            if (req_ack[u]) begin
                t_ack = k;
                pwr_on_req[u] = 1'b0;
                pwr_off_req[u] = 1'b0;
                break;
            end
        end
        if (triv) begin
            check(t_ack == 1, "R8", "immediate ack cycle", t_ack, 1);
            check(!b1 && g1 == '0, "R8", "no busy or gating", int'({b1, g1}), 0);
            check(pwr_en == model_pwr, "R8", "power unchanged", int'(pwr_en), int'(model_pwr));
        end else begin
            check(g1 == exp_mask, sg ? "R3" : "R1", "victim mask", int'(g1), int'(exp_mask));
            check(b1, "R4", "busy at cycle 1", int'(b1), 1);
            check(t_pwr == 101, "R4", "power flip cycle", t_pwr, 101);
            if (exp_mask != '0) check(t_rel == 301, "R5", "release cycle", t_rel, 301);
            check(t_ack == 401, "R6", "ack cycle", t_ack, 401);
            model_pwr[u] = on;
            check(pwr_en == model_pwr, "R4", "power state", int'(pwr_en), int'(model_pwr));
        end
        tick();
        check(req_ack == '0, "R6", "ack is one cycle", int'(req_ack), 0);
    endtask

    typedef struct packed {
        logic [3:0]   unit;
        logic         on;
        logic         sg;
        logic [N-1:0] act;
        logic         triv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{unit: 4'd5,  on: 1'b1, sg: 1'b0, act: 16'h0000, triv: 1'b0},
        '{unit: 4'd0,  on: 1'b1, sg: 1'b0, act: 16'h0020, triv: 1'b0},
        '{unit: 4'd3,  on: 1'b1, sg: 1'b0, act: 16'h0021, triv: 1'b0},
        '{unit: 4'd10, on: 1'b1, sg: 1'b0, act: 16'h0039, triv: 1'b0},
        '{unit: 4'd15, on: 1'b1, sg: 1'b1, act: 16'h0021, triv: 1'b0},
        '{unit: 4'd0,  on: 1'b0, sg: 1'b0, act: 16'h0420, triv: 1'b0},
        '{unit: 4'd5,  on: 1'b1, sg: 1'b0, act: 16'h0420, triv: 1'b1},
        '{unit: 4'd0,  on: 1'b0, sg: 1'b0, act: 16'h0420, triv: 1'b1}
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(150000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t9, t12;
        bit p12_early;
        for (int a = 0; a < N; a++)
            for (int v = 0; v < N; v++)
                impact_map[a * N + v] = in_range(a, v);
        repeat (4) tick();
        // R9: outputs during reset.
        check(pwr_en == '0 && clk_gate == '0 && req_ack == '0 && !busy, "R9",
              "reset outputs", int'({busy, req_ack, clk_gate, pwr_en}), 0);
        rst_n = 1'b1;
        tick();
        // R9: the live map changes after reset; the captured map must still be used.
        impact_map = '1;
        tick();
        check(pwr_en == '0 && !busy, "R9", "idle after reset", int'({busy, pwr_en}), 0);

        for (int i = 0; i < 8; i++) begin
            run_seq(int'(VECS[i].unit), VECS[i].on, VECS[i].sg, VECS[i].act, VECS[i].triv);
        end

        // R7: two requests at once; the lower index goes first and the other waits.
        task_active = '0;
        stop_go = 1'b0;
        pwr_on_req[12] = 1'b1;
        pwr_on_req[9] = 1'b1;
        t9 = 0;
        t12 = 0;
        p12_early = 1'b0;
        for (int k = 1; k <= 900; k++) begin
            tick();
            if (t9 == 0 && pwr_en[12]) p12_early = 1'b1;
            if (req_ack[9]) begin t9 = k; pwr_on_req[9] = 1'b0; end
            if (req_ack[12]) begin t12 = k; pwr_on_req[12] = 1'b0; break; end
        end
        check(t9 == 401, "R7", "lower index ack cycle", t9, 401);
        check(!p12_early, "R7", "waiting unit untouched", int'(p12_early), 0);
        check(t12 == 802, "R7", "second ack cycle", t12, 802);
        model_pwr[9] = 1'b1;
        model_pwr[12] = 1'b1;
        check(pwr_en == model_pwr, "R7", "final power", int'(pwr_en), int'(model_pwr));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule